// File: doc/BRIEF.md
# Circular Sampling-Window Position Tracker

This block is a cycle-level digital model of a free-running circular chain of 1024 sampling cells. A run of four adjacent cells is marked active at all times. On every enabled clock the run moves one cell forward, and it wraps from the top cell back to cell 0 without a pause. The leading cell of the run is called the head. Each time the head advances, the oldest cell at the tail drops out of the run, so the run never grows or shrinks.

A synchronous stop input freezes the run in whichever cell it has reached. The head index then stays constant so that a later readout can be aligned to the trigger. A frozen flag reports the halted state. A restart pulse releases the hold, and advancing resumes from the frozen head. The run moves continuously until it is stopped, so the ring acts as a circular pipeline that covers the trigger latency.

Top module: `ring_window_tracker`

## Requirements
- R1: While rst_ni is low, head_o is 3, cell_mask_o has bits 0 to 3 set and all others clear, and frozen_o is 0.
- R2: cell_mask_o always has exactly four bits set. They are bit head_o and the three cells below it, taken modulo 1024 (cell_mask_o bit i is set exactly when (head_o - i) mod 1024 is less than 4).
- R3: At a rising edge where frozen_o is 0, stop_i is 0 and enable_i is 1, head_o increases by one and the window moves one cell.
- R4: An advance from head 1023 gives head 0. The window can then straddle the ring end, for example cells 1022, 1023, 0 and 1 when head_o is 1.
- R5: At a rising edge where frozen_o is 0, stop_i is 0 and enable_i is 0, head_o and cell_mask_o keep their values.
- R6: At a rising edge where frozen_o is 0 and stop_i is 1, frozen_o becomes 1 and head_o does not move at that edge. This holds whatever the value of enable_i.
- R7: While frozen_o is 1 and no release occurs, frozen_o stays 1, and head_o and cell_mask_o stay constant whatever the value of enable_i.
- R8: At a rising edge where frozen_o is 1, restart_i is 1 and stop_i is 0, frozen_o returns to 0 and head_o stays the same at that edge. Advancing resumes from that head at the following enabled edge.
- R9: When frozen_o is 1, stop_i wins over restart_i if both are high at the same edge. While frozen_o is 0, restart_i has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one tick per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Lets the window advance on this tick |
| stop_i | input | 1 | Synchronous freeze request |
| restart_i | input | 1 | Releases a frozen window |
| cell_mask_o | output | 1024 | One bit per cell; 1 = cell active |
| head_o | output | 10 | Index of the leading active cell |
| frozen_o | output | 1 | High from the stop until the release |

## Verification
The bench runs the head through the full ring and across the 1023-to-0 wrap, comparing the whole 1024-bit mask after every tick. A mask whose rotation or wrap slipped would show five or three active cells, or cells that no longer sit below the head. Stop is tested both with and without enable, and at the edge where stop is raised a design that still advances would report a head one cell past the trigger. The bench also raises stop and restart together while frozen, and restart alone while running. A wrong priority would release the hold, and a design that does not ignore a stray restart would upset the run or the flag.

// File: rtl/ring_window_pkg.sv
package ring_window_pkg;
  typedef enum logic {
    RUN_ST  = 1'b0,
    HOLD_ST = 1'b1
  } run_state_e;
endpackage

// File: rtl/ring_window_ctrl.sv
module ring_window_ctrl
  import ring_window_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic stop_i,
  input  logic restart_i,
  output logic advance_o,
  output logic frozen_o
);
  run_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RUN_ST:  if (stop_i) state_d = HOLD_ST;
      HOLD_ST: if (restart_i && !stop_i) state_d = RUN_ST;
      default: state_d = RUN_ST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RUN_ST;
    else         state_q <= state_d;
  end

  // the stop edge itself already holds the head
  assign advance_o = (state_q == RUN_ST) && enable_i && !stop_i;
  assign frozen_o  = (state_q == HOLD_ST);
endmodule

// File: rtl/ring_head_counter.sv
module ring_head_counter #(
  parameter int CELLS = 1024,
  parameter int WIN   = 4,
  localparam int IDX_W = $clog2(CELLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  output logic [IDX_W-1:0] head_o
);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(CELLS - 1);
  localparam logic [IDX_W-1:0] START = IDX_W'(WIN - 1);

  logic [IDX_W-1:0] head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        head_q <= START;
    else if (advance_i) head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
  end

  assign head_o = head_q;
endmodule

// File: rtl/ring_cell_mask.sv
module ring_cell_mask #(
  parameter int CELLS = 1024,
  parameter int WIN   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  output logic [CELLS-1:0] mask_o
);
  logic [CELLS-1:0] mask_q;

  // each cell copies its lower neighbour; cell 0 takes the top cell
  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    localparam int PREV = (i + CELLS - 1) % CELLS;
    localparam logic INIT = (i < WIN);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mask_q[i] <= INIT;
      else if (advance_i) mask_q[i] <= mask_q[PREV];
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/ring_window_tracker.sv
module ring_window_tracker #(
  parameter int CELLS = 1024,
  parameter int WIN   = 4,
  localparam int IDX_W = $clog2(CELLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             stop_i,
  input  logic             restart_i,
  output logic [CELLS-1:0] cell_mask_o,
  output logic [IDX_W-1:0] head_o,
  output logic             frozen_o
);
  logic advance;

  ring_window_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .stop_i    (stop_i),
    .restart_i (restart_i),
    .advance_o (advance),
    .frozen_o  (frozen_o)
  );

  ring_head_counter #(.CELLS(CELLS), .WIN(WIN)) u_head (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (advance),
    .head_o    (head_o)
  );

  ring_cell_mask #(.CELLS(CELLS), .WIN(WIN)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (advance),
    .mask_o    (cell_mask_o)
  );
endmodule

// File: rtl/ring_window_tracker_chk.sv
module ring_window_tracker_chk #(
  parameter int CELLS = 1024,
  parameter int WIN   = 4,
  localparam int IDX_W = $clog2(CELLS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             stop_i,
  input logic             restart_i,
  input logic [CELLS-1:0] cell_mask_o,
  input logic [IDX_W-1:0] head_o,
  input logic             frozen_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELLS - 1);
  logic [IDX_W-1:0] head_nxt;
  assign head_nxt = (head_o == LAST) ? '0 : head_o + 1'b1;

  // R2
  win_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cell_mask_o) == WIN);

  // R2
  win_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_mask_o[head_o] && !cell_mask_o[head_nxt]);

  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frozen_o && !stop_i && enable_i) |=> head_o == $past(head_nxt));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frozen_o && !stop_i && !enable_i) |=> $stable(head_o) && $stable(cell_mask_o));

  // R6
  stop_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frozen_o && stop_i) |=> frozen_o && $stable(head_o));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && !restart_i) |=> frozen_o && $stable(head_o) && $stable(cell_mask_o));

  // R8
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && restart_i && !stop_i) |=> !frozen_o && $stable(head_o));

  // R9
  stop_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && restart_i && stop_i) |=> frozen_o);
endmodule

bind ring_window_tracker ring_window_tracker_chk #(.CELLS(CELLS), .WIN(WIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .stop_i      (stop_i),
  .restart_i   (restart_i),
  .cell_mask_o (cell_mask_o),
  .head_o      (head_o),
  .frozen_o    (frozen_o)
);

// File: tb/ring_window_tracker_test.sv
module ring_window_tracker_test;
  localparam int CELLS = 1024;
  localparam int IW    = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0, stop_i = 1'b0, restart_i = 1'b0;
  logic [CELLS-1:0] cell_mask_o;
  logic [IW-1:0] head_o;
  logic frozen_o;

  int checks = 0, fails = 0;
  logic [IW-1:0] m_head = 3;
  logic m_frozen = 1'b0;

  logic [IW-1:0] q_head[$];
  logic q_frz[$];
  string q_tag[$];

  always #2 clk = ~clk;

  ring_window_tracker uut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .stop_i(stop_i),
    .restart_i(restart_i), .cell_mask_o(cell_mask_o), .head_o(head_o),
    .frozen_o(frozen_o)
  );

  function automatic logic [CELLS-1:0] exp_mask(logic [IW-1:0] h);
    logic [CELLS-1:0] m;
    for (int i = 0; i < CELLS; i++) begin
      logic [IW-1:0] d;
      d = h - IW'(i);
      m[i] = (d < 4);
    end
    return m;
  endfunction

  task automatic compare(string tag, logic [IW-1:0] eh, logic ef);
    checks++;
    if (head_o !== eh || frozen_o !== ef || cell_mask_o !== exp_mask(eh)) begin
      fails++;
      $display("FAIL %s: head=%0d frozen=%0b ones=%0d expected head=%0d frozen=%0b",
               tag, head_o, frozen_o, $countones(cell_mask_o), eh, ef);
    end
  endtask

  // driver: applies one tick of stimulus and queues the expected result
  task automatic step(logic en, logic st, logic rs, string tag);
    @(negedge clk);
    enable_i = en; stop_i = st; restart_i = rs;
    if (m_frozen) begin
      if (rs && !st) m_frozen = 1'b0;
    end else if (st) m_frozen = 1'b1;
    else if (en) m_head = m_head + 1'b1;
    q_head.push_back(m_head);
    q_frz.push_back(m_frozen);
    q_tag.push_back(tag);
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    #1;
    if (q_head.size() != 0) compare(q_tag.pop_front(), q_head.pop_front(), q_frz.pop_front());
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    #5;
    compare("R1 reset state", 10'd3, 1'b0);
    #4 rst_ni = 1'b1;
    for (int k = 0; k < 10; k++) step(1, 0, 0, "R3 advance");
    for (int k = 0; k < 3; k++)  step(0, 0, 0, "R5 enable low holds");
    step(0, 1, 0, "R6 stop without enable");
    for (int k = 0; k < 3; k++)  step(1, 0, 0, "R7 frozen ignores enable");
    step(1, 1, 1, "R9 stop beats restart");
    step(0, 0, 1, "R8 restart releases");
    step(1, 0, 0, "R8 resume from frozen head");
    step(1, 0, 1, "R9 restart ignored when running");
    while (m_head != 10'd1020) step(1, 0, 0, "R2 window tracks head");
    for (int k = 0; k < 6; k++)  step(1, 0, 0, "R4 wrap across ring end");
    step(1, 1, 0, "R6 stop with enable");
    step(1, 0, 0, "R7 hold after stop");
    step(0, 0, 0, "R7 hold idle");
    step(1, 0, 1, "R8 release with enable");
    step(1, 0, 0, "R8 first advance after release");
    step(0, 0, 0, "R5 idle after release");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule